// File: doc/BRIEF.md
# Privilege-Banked Vector Loop Control Registers

This block keeps the control state that a scalar core needs to run an instruction as a loop over a group of registers: an upper bound on the loop length, the loop length currently in force, and two element offsets (one for the source side, one for the destination side). The block holds three independent copies of this state: one for machine, one for supervisor and one for user privilege. The current privilege input picks which copy every read, write and status output refers to, so a trap handler can run its own loops without disturbing the interrupted program's settings.

Software reaches the state through a CSR-style port. The port offers a bound register, a length register and a packed register. The packed register moves the whole state in one access: both lengths are shown minus one, and the offsets are held inside the new length. Writes take effect on the next clock edge. Reads and the active-state outputs are combinational views of the bank that is currently selected. A stop flag tells the loop sequencer that the active length is zero.

Top module: `vlen_csr_bank`

## Requirements
- R1: After a synchronous active-high reset, every bank holds bound 64, length 64, source offset 0 and destination offset 0.
- R2: Privilege encoding 3 selects the machine bank, 1 the supervisor bank, and 0 or 2 the user bank. Reads, writes and the act_* outputs use only the selected bank, and a write leaves the other two banks unchanged.
- R3: A write with csr_sel = 0 (bound) stores the smaller of csr_wdata and 64 as the bound. The length and the offsets do not change.
- R4: A write with csr_sel = 1 (length) stores the smaller of csr_wdata and the bank's current bound as the length.
- R5: A write with csr_sel = 2 (packed) sets the bound to wdata[5:0]+1. It then sets the length to the smaller of wdata[11:6]+1 and that new bound.
- R6: The same packed write stores the source offset as the smaller of wdata[17:12] and the new length minus one, and the destination offset as the smaller of wdata[23:18] and the new length minus one.
- R7: A read with csr_sel = 2 returns the bound minus one in bits 5:0, the length minus one in bits 11:6, the source offset in bits 17:12, the destination offset in bits 23:18, and zero above bit 23. Each minus-one field is taken modulo 64, so a stored 0 reads as 63.
- R8: Reads with csr_sel = 0 and csr_sel = 1 return the stored bound and length, zero-extended and unchanged.
- R9: loop_stop is high exactly when the selected bank's length is zero.
- R10: csr_sel = 3 reads as zero, and a write with it changes no bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv | input | 2 | Current privilege level; selects the bank |
| csr_we | input | 1 | Write strobe for the selected register |
| csr_sel | input | 2 | Register select: 0 bound, 1 length, 2 packed, 3 none |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data from the selected bank |
| act_maxlen | output | 7 | Bound of the selected bank |
| act_len | output | 7 | Length of the selected bank |
| act_src_off | output | 6 | Source offset of the selected bank |
| act_dst_off | output | 6 | Destination offset of the selected bank |
| loop_stop | output | 1 | High when the active length is zero |

## Verification
Bound writes are tried with values above 64, exactly at 64 and below 64, which shows whether the clamp uses the right limit. Length writes are tried above and below a reduced bound, and with zero. These show whether the clamp follows the live bound, and they drive the stop flag and the modulo-64 packed readback. Packed writes are tried with offsets above and below the new length, and with a length field larger than the bound field. This shows the order of the updates and which length the offsets are clamped against. After each write, the same state is read under every privilege code, so a write that leaks into another bank, or a reserved code that is mapped wrongly, shows up.

// File: rtl/vlbank_pkg.sv
package vlbank_pkg;

    localparam int VL_LIMIT   = 64;
    localparam int VL_LEN_W   = $clog2(VL_LIMIT + 1);
    localparam int VL_FIELD_W = $clog2(VL_LIMIT);
    localparam int VL_BANKS   = 3;
    localparam int VL_BANK_W  = $clog2(VL_BANKS);

    // packed register field positions (software-visible layout)
    localparam int PK_MAX_LSB = 0;
    localparam int PK_LEN_LSB = PK_MAX_LSB + VL_FIELD_W;
    localparam int PK_SRC_LSB = PK_LEN_LSB + VL_FIELD_W;
    localparam int PK_DST_LSB = PK_SRC_LSB + VL_FIELD_W;
    localparam int PK_USED_W  = PK_DST_LSB + VL_FIELD_W;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } vl_priv_e;

    typedef enum logic [1:0] {
        SEL_BOUND  = 2'd0,
        SEL_LENGTH = 2'd1,
        SEL_PACKED = 2'd2,
        SEL_NONE   = 2'd3
    } vl_sel_e;

    typedef struct packed {
        logic [VL_LEN_W-1:0]   maxlen;
        logic [VL_LEN_W-1:0]   len;
        logic [VL_FIELD_W-1:0] src_off;
        logic [VL_FIELD_W-1:0] dst_off;
    } vl_state_t;

    localparam vl_state_t VL_RESET_STATE = '{
        maxlen:  VL_LEN_W'(VL_LIMIT),
        len:     VL_LEN_W'(VL_LIMIT),
        src_off: '0,
        dst_off: '0
    };

    localparam logic [VL_BANK_W-1:0] BANK_M = VL_BANK_W'(0);
    localparam logic [VL_BANK_W-1:0] BANK_S = VL_BANK_W'(1);
    localparam logic [VL_BANK_W-1:0] BANK_U = VL_BANK_W'(2);

    function automatic logic [VL_BANK_W-1:0] bank_of(input logic [1:0] p);
        case (vl_priv_e'(p))
            PRIV_MACH:  return BANK_M;
            PRIV_SUPER: return BANK_S;
            default:    return BANK_U;
        endcase
    endfunction

    function automatic logic [VL_LEN_W-1:0] min_len(input logic [VL_LEN_W-1:0] a,
                                                    input logic [VL_LEN_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/vlen_next_state.sv
module vlen_next_state
    import vlbank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  vl_state_t         cur,
    input  logic [1:0]        sel,
    input  logic [XLEN-1:0]   wdata,
    output vl_state_t         nxt
);
    localparam logic [XLEN-1:0] LIMIT_X = XLEN'(VL_LIMIT);

    logic [VL_LEN_W-1:0]   bound_clamped;
    logic [VL_LEN_W-1:0]   len_clamped;
    logic [VL_LEN_W-1:0]   pk_bound;
    logic [VL_LEN_W-1:0]   pk_len_req;
    logic [VL_LEN_W-1:0]   pk_len;
    logic [VL_LEN_W-1:0]   pk_off_lim;
    logic [VL_FIELD_W-1:0] pk_src_f;
    logic [VL_FIELD_W-1:0] pk_dst_f;
    logic [VL_FIELD_W-1:0] pk_src;
    logic [VL_FIELD_W-1:0] pk_dst;

    always_comb begin
        bound_clamped = (wdata > LIMIT_X) ? VL_LEN_W'(VL_LIMIT) : wdata[VL_LEN_W-1:0];
        len_clamped   = (wdata > XLEN'(cur.maxlen)) ? cur.maxlen : wdata[VL_LEN_W-1:0];

        // packed: bound first, then length against the new bound, then offsets
        pk_bound   = {1'b0, wdata[PK_MAX_LSB +: VL_FIELD_W]} + VL_LEN_W'(1);
        pk_len_req = {1'b0, wdata[PK_LEN_LSB +: VL_FIELD_W]} + VL_LEN_W'(1);
        pk_len     = min_len(pk_len_req, pk_bound);
        pk_off_lim = pk_len - VL_LEN_W'(1);
        pk_src_f   = wdata[PK_SRC_LSB +: VL_FIELD_W];
        pk_dst_f   = wdata[PK_DST_LSB +: VL_FIELD_W];
        pk_src     = ({1'b0, pk_src_f} > pk_off_lim) ? pk_off_lim[VL_FIELD_W-1:0] : pk_src_f;
        pk_dst     = ({1'b0, pk_dst_f} > pk_off_lim) ? pk_off_lim[VL_FIELD_W-1:0] : pk_dst_f;

        nxt = cur;
        case (vl_sel_e'(sel))
            SEL_BOUND:  nxt.maxlen = bound_clamped;
            SEL_LENGTH: nxt.len    = len_clamped;
            SEL_PACKED: begin
                nxt.maxlen  = pk_bound;
                nxt.len     = pk_len;
                nxt.src_off = pk_src;
                nxt.dst_off = pk_dst;
            end
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/vlen_bank_reg.sv
module vlen_bank_reg
    import vlbank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  vl_state_t d,
    output vl_state_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= VL_RESET_STATE;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/vlen_read_view.sv
module vlen_read_view
    import vlbank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  vl_state_t       st,
    input  logic [1:0]      sel,
    output logic [XLEN-1:0] rdata
);
    logic [VL_LEN_W-1:0]  max_m1;
    logic [VL_LEN_W-1:0]  len_m1;
    logic [PK_USED_W-1:0] packed_img;

    always_comb begin
        max_m1     = st.maxlen - VL_LEN_W'(1);
        len_m1     = st.len - VL_LEN_W'(1);
        packed_img = '0;
        packed_img[PK_MAX_LSB +: VL_FIELD_W] = max_m1[VL_FIELD_W-1:0];
        packed_img[PK_LEN_LSB +: VL_FIELD_W] = len_m1[VL_FIELD_W-1:0];
        packed_img[PK_SRC_LSB +: VL_FIELD_W] = st.src_off;
        packed_img[PK_DST_LSB +: VL_FIELD_W] = st.dst_off;
        case (vl_sel_e'(sel))
            SEL_BOUND:  rdata = XLEN'(st.maxlen);
            SEL_LENGTH: rdata = XLEN'(st.len);
            SEL_PACKED: rdata = XLEN'(packed_img);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/vlen_csr_bank.sv
module vlen_csr_bank
    import vlbank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            priv,
    input  logic                  csr_we,
    input  logic [1:0]            csr_sel,
    input  logic [XLEN-1:0]       csr_wdata,
    output logic [XLEN-1:0]       csr_rdata,
    output logic [VL_LEN_W-1:0]   act_maxlen,
    output logic [VL_LEN_W-1:0]   act_len,
    output logic [VL_FIELD_W-1:0] act_src_off,
    output logic [VL_FIELD_W-1:0] act_dst_off,
    output logic                  loop_stop
);
    logic [VL_BANK_W-1:0] cur_bank;
    vl_state_t            bank_q [VL_BANKS];
    vl_state_t            active;
    vl_state_t            active_nxt;

    assign cur_bank = bank_of(priv);

    always_comb begin
        active = bank_q[0];
        for (int i = 0; i < VL_BANKS; i++)
            if (cur_bank == VL_BANK_W'(i))
                active = bank_q[i];
    end

    vlen_next_state #(.XLEN(XLEN)) u_next (
        .cur   (active),
        .sel   (csr_sel),
        .wdata (csr_wdata),
        .nxt   (active_nxt)
    );

    for (genvar b = 0; b < VL_BANKS; b++) begin : g_bank
        logic hit;
        assign hit = csr_we && (cur_bank == VL_BANK_W'(b)) &&
                     (vl_sel_e'(csr_sel) != SEL_NONE);
        vlen_bank_reg u_reg (
            .clk  (clk),
            .rst  (rst),
            .load (hit),
            .d    (active_nxt),
            .q    (bank_q[b])
        );
    end

    vlen_read_view #(.XLEN(XLEN)) u_view (
        .st    (active),
        .sel   (csr_sel),
        .rdata (csr_rdata)
    );

    assign act_maxlen  = active.maxlen;
    assign act_len     = active.len;
    assign act_src_off = active.src_off;
    assign act_dst_off = active.dst_off;
    assign loop_stop   = (active.len == '0);
endmodule

// File: rtl/vlen_csr_bank_chk.sv
module vlen_csr_bank_chk
    import vlbank_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic [1:0]            priv,
    input logic                  csr_we,
    input logic [1:0]            csr_sel,
    input logic [XLEN-1:0]       csr_rdata,
    input logic [VL_LEN_W-1:0]   act_maxlen,
    input logic [VL_LEN_W-1:0]   act_len,
    input logic [VL_FIELD_W-1:0] act_src_off,
    input logic [VL_FIELD_W-1:0] act_dst_off,
    input logic                  loop_stop
);
    a_r3_bound_limit: assert property (@(posedge clk) disable iff (rst)
        act_maxlen <= VL_LEN_W'(VL_LIMIT));

    a_r4_len_within_bound: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_sel == SEL_LENGTH) |=>
            (priv != $past(priv)) || (act_len <= act_maxlen));

    a_r6_offsets_in_range: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_sel == SEL_PACKED) |=>
            (priv != $past(priv)) ||
            ({1'b0, act_src_off} < act_len && {1'b0, act_dst_off} < act_len));

    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !csr_we |=> (priv != $past(priv)) ||
            ($stable(act_len) && $stable(act_maxlen) &&
             $stable(act_src_off) && $stable(act_dst_off)));

    a_r9_stop_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (csr_sel == SEL_LENGTH && loop_stop) |-> csr_rdata == '0);

    a_r10_none_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (csr_sel == SEL_NONE) |-> csr_rdata == '0);
endmodule

bind vlen_csr_bank vlen_csr_bank_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .priv        (priv),
    .csr_we      (csr_we),
    .csr_sel     (csr_sel),
    .csr_rdata   (csr_rdata),
    .act_maxlen  (act_maxlen),
    .act_len     (act_len),
    .act_src_off (act_src_off),
    .act_dst_off (act_dst_off),
    .loop_stop   (loop_stop)
);

// File: tb/vlen_csr_bank_test.sv
module vlen_csr_bank_test;
    localparam int XLEN = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      priv = 2'd0;
    logic            csr_we = 1'b0;
    logic [1:0]      csr_sel = 2'd0;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata;
    logic [6:0]      act_maxlen;
    logic [6:0]      act_len;
    logic [5:0]      act_src_off;
    logic [5:0]      act_dst_off;
    logic            loop_stop;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model, index 0 = M, 1 = S, 2 = U
    logic [6:0] m_max [3];
    logic [6:0] m_len [3];
    logic [5:0] m_src [3];
    logic [5:0] m_dst [3];

    vlen_csr_bank #(.XLEN(XLEN)) uut (
        .clk(clk), .rst(rst), .priv(priv), .csr_we(csr_we), .csr_sel(csr_sel),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .act_maxlen(act_maxlen),
        .act_len(act_len), .act_src_off(act_src_off), .act_dst_off(act_dst_off),
        .loop_stop(loop_stop)
    );

    always #10 clk = ~clk;

    function automatic int bidx(input logic [1:0] p);
        if (p == 2'd3) return 0;
        if (p == 2'd1) return 1;
        return 2;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_write(input logic [1:0] p, input logic [1:0] s, input logic [31:0] d);
        int b = bidx(p);
        logic [6:0] nl;
        case (s)
            2'd0: m_max[b] = (d > 64) ? 7'd64 : d[6:0];
            2'd1: m_len[b] = (d > {25'd0, m_max[b]}) ? m_max[b] : d[6:0];
            2'd2: begin
                m_max[b] = {1'b0, d[5:0]} + 7'd1;
                nl = {1'b0, d[11:6]} + 7'd1;
                if (nl > m_max[b]) nl = m_max[b];
                m_len[b] = nl;
                m_src[b] = ({1'b0, d[17:12]} > nl - 7'd1) ? 6'(nl - 7'd1) : d[17:12];
                m_dst[b] = ({1'b0, d[23:18]} > nl - 7'd1) ? 6'(nl - 7'd1) : d[23:18];
            end
            default: ;
        endcase
    endtask

    task automatic wr(input logic [1:0] p, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        priv = p; csr_sel = s; csr_wdata = d; csr_we = 1'b1;
        @(negedge clk);
        csr_we = 1'b0;
        model_write(p, s, d);
    endtask

    task automatic check_bank(input logic [1:0] p, input string tag);
        int b = bidx(p);
        logic [6:0] mm1 = m_max[b] - 7'd1;
        logic [6:0] lm1 = m_len[b] - 7'd1;
        priv = p;
        csr_sel = 2'd0; #1;
        chk({tag, " bound read"}, csr_rdata, {25'd0, m_max[b]});
        csr_sel = 2'd1; #1;
        chk({tag, " length read"}, csr_rdata, {25'd0, m_len[b]});
        csr_sel = 2'd2; #1;
        chk({tag, " packed read"}, csr_rdata,
            {8'd0, m_dst[b], m_src[b], lm1[5:0], mm1[5:0]});
        csr_sel = 2'd3; #1;
        chk({tag, " none read"}, csr_rdata, 32'd0);
        chk({tag, " act outputs"}, {6'd0, act_maxlen, act_len, act_src_off, act_dst_off},
            {6'd0, m_max[b], m_len[b], m_src[b], m_dst[b]});
        chk({tag, " loop_stop"}, {31'd0, loop_stop}, {31'd0, m_len[b] == 7'd0});
    endtask

    task automatic check_all(input string tag);
        check_bank(2'd3, {tag, " M"});
        check_bank(2'd1, {tag, " S"});
        check_bank(2'd0, {tag, " U"});
        check_bank(2'd2, {tag, " U-alias R2"});
    endtask

    task automatic t_reset;
        for (int i = 0; i < 3; i++) begin
            m_max[i] = 7'd64; m_len[i] = 7'd64; m_src[i] = 6'd0; m_dst[i] = 6'd0;
        end
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset R8");
    endtask

    task automatic t_bound;
        wr(2'd0, 2'd0, 32'd100);
        check_all("R3 bound above limit");
        wr(2'd0, 2'd0, 32'h8000_0040);
        check_all("R3 bound huge");
        wr(2'd0, 2'd0, 32'd64);
        check_all("R3 bound at limit");
        wr(2'd0, 2'd0, 32'd40);
        check_all("R3 bound below, length kept");
    endtask

    task automatic t_length;
        wr(2'd0, 2'd1, 32'd50);
        check_all("R4 length above bound");
        wr(2'd0, 2'd1, 32'd7);
        check_all("R4 length below bound R8");
    endtask

    task automatic t_isolation;
        wr(2'd1, 2'd0, 32'd10);
        wr(2'd1, 2'd1, 32'd3);
        check_all("R2 supervisor write isolated");
        wr(2'd2, 2'd1, 32'd5);
        check_all("R2 reserved code writes user");
    endtask

    task automatic t_packed;
        wr(2'd3, 2'd2, {8'hff, 6'd5, 6'd30, 6'd20, 6'd15});
        check_all("R5 R6 R7 packed offsets clamp");
        wr(2'd3, 2'd2, {8'h00, 6'd63, 6'd3, 6'd9, 6'd63});
        check_all("R5 R6 R7 packed full bound");
        wr(2'd1, 2'd2, {8'h00, 6'd0, 6'd0, 6'd0, 6'd0});
        check_all("R5 R6 packed minimum");
    endtask

    task automatic t_stop;
        wr(2'd0, 2'd1, 32'd0);
        check_all("R9 R7 zero length");
        wr(2'd0, 2'd1, 32'd2);
        check_all("R9 length restored");
    endtask

    task automatic t_none;
        wr(2'd3, 2'd3, 32'hffff_ffff);
        wr(2'd0, 2'd3, 32'd1);
        check_all("R10 none select ignored");
    endtask

    initial begin
        t_reset();
        t_bound();
        t_length();
        t_isolation();
        t_packed();
        t_stop();
        t_none();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule